// File: doc/BRIEF.md
# Byte-Pair Upload Command Receiver

This block is the target end of a lock-step byte link. The host sends one byte at a time, and for every byte the block accepts it returns exactly one reply byte on the following cycle. A session opens with two handshake stages. The block answers a run of "W" bytes with "R" and then a run of "B" bytes with "W". After that comes one command byte that asks for either upload-then-execute or upload-then-flash. Address and length fields follow, then the payload, a checksum and a closing two-byte dummy word.

The payload goes out on a one-byte write port at increasing addresses. The checksum is a 12-bit additive sum of the payload bytes. The closing dummy word is answered with a two-letter status. A good execute session ends with a one-cycle call request carrying the address. A good flash session raises a burn request, and the block holds off its reply until an external programmer reports pass or fail. The block then goes back to the first handshake stage.

Top module: `byte_link_loader`

## Requirements
- R1: In handshake stage one, an accepted 57h ("W") is answered with 52h ("R") and moves to stage two; any other byte is echoed unchanged and the stage is kept.
- R2: In handshake stage two, an accepted 42h ("B") is answered with 57h ("W") and moves to the command step; any other byte is echoed unchanged and the stage is kept.
- R3: Command byte 58h ("X", execute) or 55h ("U", flash) is echoed and starts the address field. Any other command byte is echoed, the next two accepted bytes are answered 42h then 58h ("B","X"), and the block returns to stage one.
- R4: The address and the length are each four bytes, most significant byte first, and every byte is echoed.
- R5: Payload byte i is echoed, and in the same cycle as its echo wr_en is high for one cycle with wr_addr = address + i and wr_data = the byte.
- R6: A length of zero skips the payload: the next byte after the length is the checksum MSB, and the expected sum is zero.
- R7: The checksum is two echoed bytes, MSB first. Only its low 12 bits are compared with the low 12 bits of the sum of all payload bytes; the upper four bits have no effect on the result.
- R8: The two dummy bytes are answered "OK" (4Fh,4Bh) on success, "BC" (42h,43h) on a checksum mismatch, and "BF" (42h,46h) on a failed burn.
- R9: An execute session with a good checksum pulses exec_req for one cycle, together with the "K" reply, with exec_addr = the address.
- R10: A flash session with a good checksum raises burn_req, with burn_addr and burn_len, when the first dummy byte is accepted. While burn_req is high, in_ready is low and no reply is sent. One cycle after burn_done, the reply is "O" if burn_ok is high and "B" if it is low.
- R11: Every accepted byte gets its single reply exactly one cycle later, except during a burn wait. After the second dummy reply the block is back in handshake stage one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block can take a byte (low during a burn wait) |
| out_valid | output | 1 | One-cycle reply strobe |
| out_data | output | 8 | Reply byte |
| wr_en | output | 1 | Payload write strobe |
| wr_addr | output | 32 | Payload write address |
| wr_data | output | 8 | Payload write byte |
| exec_req | output | 1 | One-cycle call request |
| exec_addr | output | 32 | Call target |
| burn_req | output | 1 | Flash burn request, held until done |
| burn_addr | output | 32 | Burn start address |
| burn_len | output | 32 | Burn length in bytes |
| burn_done | input | 1 | Burn finished pulse |
| burn_ok | input | 1 | Burn result, sampled with burn_done |

## Verification
The hardest state to reach is the burn wait. Getting there needs a full handshake, a flash command, consistent address and length fields, a payload and a checksum that matches after masking. The bench builds whole sessions from seeded random payloads and lengths, and computes the sum in its own function. It then holds burn_done back for several cycles to confirm the stall and the held request, and covers both burn outcomes. Directed sessions add a zero length, a checksum that differs only in its upper nibble, a truly bad checksum and an unknown command.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    typedef enum logic [3:0] {
        ST_SYNC_W, ST_SYNC_B, ST_CMD, ST_BAD1, ST_BAD2, ST_ADDR,
        ST_LEN, ST_DATA, ST_CK, ST_DUM1, ST_BURN, ST_DUM2
    } ldr_state_e;

    typedef enum logic [1:0] { RES_OK, RES_BADCK, RES_BADFL } ldr_res_e;

    localparam logic [7:0] CH_W = 8'h57;
    localparam logic [7:0] CH_R = 8'h52;
    localparam logic [7:0] CH_B = 8'h42;
    localparam logic [7:0] CH_X = 8'h58;
    localparam logic [7:0] CH_U = 8'h55;
    localparam logic [7:0] CH_O = 8'h4F;
    localparam logic [7:0] CH_K = 8'h4B;
    localparam logic [7:0] CH_C = 8'h43;
    localparam logic [7:0] CH_F = 8'h46;
endpackage

// File: rtl/ldr_csum.sv
module ldr_csum #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [7:0]   din,
    output logic [W-1:0] sum
);
    logic [W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr)      sum_d = '0;
        else if (add) sum_d = sum_q + W'(din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/ldr_field.sv
module ldr_field #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [7:0]   din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (shift) q_d = {q_q[W-9:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/byte_link_loader.sv
module byte_link_loader
    import ldr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32,
    parameter int CSUM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              exec_req,
    output logic [ADDR_W-1:0] exec_addr,
    output logic              burn_req,
    output logic [ADDR_W-1:0] burn_addr,
    output logic [LEN_W-1:0]  burn_len,
    input  logic              burn_done,
    input  logic              burn_ok
);
    localparam int AB    = ADDR_W / 8;
    localparam int LB    = LEN_W / 8;
    localparam int MAXB  = (AB > LB) ? AB : LB;
    localparam int IDX_W = (MAXB > 2) ? $clog2(MAXB) : 1;

    typedef struct packed {
        ldr_state_e        state;
        logic              flash;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  cnt;
        logic [15:0]       ck;
        ldr_res_e          res;
        logic              ov;
        logic [7:0]        od;
        logic              we;
        logic [ADDR_W-1:0] wa;
        logic [7:0]        wd;
        logic              br;
        logic              ex;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              acc;
    logic              sum_clr, sum_add, sh_addr, sh_len;
    logic [CSUM_W-1:0] sum;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  len_next;
    logic              ck_good;

    assign in_ready = (st_q.state != ST_BURN);
    assign acc      = in_valid && in_ready;
    assign len_next = {len_q[LEN_W-9:0], in_data};
    assign ck_good  = (st_q.ck[CSUM_W-1:0] == sum);

    ldr_csum #(.W(CSUM_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(sum_add),
        .din(in_data), .sum(sum)
    );

    ldr_field #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .shift(sh_addr), .din(in_data), .q(addr_q)
    );

    ldr_field #(.W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .shift(sh_len), .din(in_data), .q(len_q)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.we = 1'b0;
        st_d.ex = 1'b0;
        sum_clr = 1'b0;
        sum_add = 1'b0;
        sh_addr = 1'b0;
        sh_len  = 1'b0;
        if (acc) begin
            st_d.ov = 1'b1;
            st_d.od = in_data;
            unique case (st_q.state)
                ST_SYNC_W: if (in_data == CH_W) begin
                    st_d.od    = CH_R;
                    st_d.state = ST_SYNC_B;
                end
                ST_SYNC_B: if (in_data == CH_B) begin
                    st_d.od    = CH_W;
                    st_d.state = ST_CMD;
                end
                ST_CMD: begin
                    sum_clr    = 1'b1;
                    st_d.idx   = '0;
                    st_d.flash = (in_data == CH_U);
                    st_d.state = (in_data == CH_X || in_data == CH_U) ? ST_ADDR : ST_BAD1;
                end
                ST_BAD1: begin
                    st_d.od    = CH_B;
                    st_d.state = ST_BAD2;
                end
                ST_BAD2: begin
                    st_d.od    = CH_X;
                    st_d.state = ST_SYNC_W;
                end
                ST_ADDR: begin
                    sh_addr  = 1'b1;
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == IDX_W'(AB - 1)) begin
                        st_d.idx   = '0;
                        st_d.state = ST_LEN;
                    end
                end
                ST_LEN: begin
                    sh_len   = 1'b1;
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == IDX_W'(LB - 1)) begin
                        st_d.idx   = '0;
                        st_d.cnt   = '0;
                        st_d.state = (len_next == '0) ? ST_CK : ST_DATA;
                    end
                end
                ST_DATA: begin
                    sum_add  = 1'b1;
                    st_d.we  = 1'b1;
                    st_d.wa  = addr_q + ADDR_W'(st_q.cnt);
                    st_d.wd  = in_data;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt + 1'b1 == len_q) st_d.state = ST_CK;
                end
                ST_CK: begin
                    st_d.ck  = {st_q.ck[7:0], in_data};
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == IDX_W'(1)) begin
                        st_d.idx   = '0;
                        st_d.state = ST_DUM1;
                    end
                end
                ST_DUM1: begin
                    st_d.state = ST_DUM2;
                    if (!ck_good) begin
                        st_d.res = RES_BADCK;
                        st_d.od  = CH_B;
                    end else if (st_q.flash) begin
                        st_d.ov    = 1'b0;
                        st_d.br    = 1'b1;
                        st_d.state = ST_BURN;
                    end else begin
                        st_d.res = RES_OK;
                        st_d.od  = CH_O;
                    end
                end
                ST_DUM2: begin
                    st_d.state = ST_SYNC_W;
                    unique case (st_q.res)
                        RES_OK:    st_d.od = CH_K;
                        RES_BADCK: st_d.od = CH_C;
                        default:   st_d.od = CH_F;
                    endcase
                    st_d.ex = (st_q.res == RES_OK) && !st_q.flash;
                end
                default: st_d.state = ST_SYNC_W;
            endcase
        end else if (st_q.state == ST_BURN && burn_done) begin
            st_d.br    = 1'b0;
            st_d.ov    = 1'b1;
            st_d.res   = burn_ok ? RES_OK : RES_BADFL;
            st_d.od    = burn_ok ? CH_O : CH_B;
            st_d.state = ST_DUM2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_SYNC_W;
            st_q.res   <= RES_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign wr_en     = st_q.we;
    assign wr_addr   = st_q.wa;
    assign wr_data   = st_q.wd;
    assign exec_req  = st_q.ex;
    assign exec_addr = addr_q;
    assign burn_req  = st_q.br;
    assign burn_addr = addr_q;
    assign burn_len  = len_q;
endmodule

// File: rtl/byte_link_loader_chk.sv
module byte_link_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       exec_req,
    input logic       burn_req,
    input logic       burn_done
);
    // R11
    reply_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid || burn_req));

    // R11
    no_spurious_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid && in_ready) || $past(burn_req && burn_done)));

    // R10
    burn_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn_req |-> !in_ready);

    // R10
    burn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burn_req && !burn_done) |=> burn_req);

    // R9
    exec_with_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> (out_valid && out_data == 8'h4B));

    // R5
    write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (out_valid && out_data == wr_data));
endmodule

bind byte_link_loader byte_link_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .wr_en(wr_en),
    .wr_data(wr_data), .exec_req(exec_req), .burn_req(burn_req),
    .burn_done(burn_done)
);

// File: tb/byte_link_loader_test.sv
module byte_link_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, out_valid, wr_en, exec_req, burn_req;
    logic [7:0]  out_data, wr_data;
    logic [31:0] wr_addr, exec_addr, burn_addr, burn_len;
    logic        burn_done = 1'b0;
    logic        burn_ok = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    logic        r_v, r_we, r_ex;
    logic [7:0]  r_d, r_wd;
    logic [31:0] r_wa;

    always #2.5 clk = ~clk;

    byte_link_loader uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .exec_req(exec_req), .exec_addr(exec_addr), .burn_req(burn_req),
        .burn_addr(burn_addr), .burn_len(burn_len), .burn_done(burn_done),
        .burn_ok(burn_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_sum(input logic [7:0] p[64], input int n);
        logic [11:0] s = '0;
        for (int i = 0; i < n; i++) s = s + 12'(p[i]);
        return s;
    endfunction

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        r_v  = out_valid; r_d  = out_data;
        r_we = wr_en;     r_wa = wr_addr; r_wd = wr_data;
        r_ex = exec_req;
    endtask

    task automatic expect_reply(input string req, input logic [7:0] b, input logic [7:0] exp);
        push(b);
        chk(req, {23'd0, r_v, r_d}, {23'd0, 1'b1, exp});
    endtask

    task automatic sync_in;
        expect_reply("R1 noise echo", 8'h33, 8'h33);
        expect_reply("R1 W->R", 8'h57, 8'h52);
        expect_reply("R2 noise echo", 8'h57, 8'h57);
        expect_reply("R2 B->W", 8'h42, 8'h57);
    endtask

    // ckmode: 0 good, 1 good with upper nibble flipped, 2 bad
    task automatic session(input logic [7:0] cmd, input logic [31:0] addr,
                           input int len, input int ckmode, input logic bok);
        logic [7:0]  pay[64];
        logic [15:0] ck;
        logic        good;
        sync_in();
        expect_reply("R3 cmd echo", cmd, cmd);
        for (int i = 3; i >= 0; i--) expect_reply("R4 addr echo", addr[i*8 +: 8], addr[i*8 +: 8]);
        for (int i = 3; i >= 0; i--) expect_reply("R4 len echo", 8'(len >> (i*8)), 8'(len >> (i*8)));
        for (int i = 0; i < len; i++) begin
            pay[i] = 8'($urandom);
            push(pay[i]);
            chk("R5 data echo", {23'd0, r_v, r_d}, {23'd0, 1'b1, pay[i]});
            chk("R5 wr_en", {31'd0, r_we}, 32'd1);
            chk("R5 wr_addr", r_wa, addr + 32'(i));
            chk("R5 wr_data", {24'd0, r_wd}, {24'd0, pay[i]});
        end
        for (int i = len; i < 64; i++) pay[i] = 8'h00;
        ck = {4'h0, model_sum(pay, len)};
        if (ckmode == 1) ck = ck ^ 16'hA000;
        if (ckmode == 2) ck = {4'h0, ck[11:0] + 12'd1};
        good = (ckmode != 2);
        expect_reply("R7 ck msb echo", ck[15:8], ck[15:8]);
        expect_reply(len == 0 ? "R6 ck lsb echo" : "R7 ck lsb echo", ck[7:0], ck[7:0]);
        if (good && cmd == 8'h55) begin
            push(8'h00);
            chk("R10 no reply while burning", {31'd0, r_v}, 32'd0);
            chk("R10 burn_req", {31'd0, burn_req}, 32'd1);
            chk("R10 burn_addr", burn_addr, addr);
            chk("R10 burn_len", burn_len, 32'(len));
            repeat (3) @(negedge clk);
            chk("R10 stall in_ready", {31'd0, in_ready}, 32'd0);
            chk("R10 still quiet", {30'd0, burn_req, out_valid}, 32'd2);
            burn_done = 1'b1; burn_ok = bok;
            @(negedge clk);
            burn_done = 1'b0;
            chk("R10 reply after done", {23'd0, out_valid, out_data}, {23'd0, 1'b1, bok ? 8'h4F : 8'h42});
            chk("R10 burn_req dropped", {31'd0, burn_req}, 32'd0);
            push(8'h00);
            chk("R8 flash second", {23'd0, r_v, r_d}, {23'd0, 1'b1, bok ? 8'h4B : 8'h46});
            chk("R9 no exec on flash", {31'd0, r_ex}, 32'd0);
        end else begin
            expect_reply("R8 first status", 8'h00, good ? 8'h4F : 8'h42);
            push(8'h00);
            chk("R8 second status", {23'd0, r_v, r_d}, {23'd0, 1'b1, good ? 8'h4B : 8'h43});
            chk("R9 exec_req", {31'd0, r_ex}, {31'd0, good && cmd == 8'h58});
            if (good && cmd == 8'h58) chk("R9 exec_addr", exec_addr, addr);
        end
        @(negedge clk);
        chk("R9 exec pulse one cycle", {31'd0, exec_req}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        chk("R11 reset in_ready", {31'd0, in_ready}, 32'd1);
        chk("R11 reset outputs", {27'd0, out_valid, wr_en, exec_req, burn_req, 1'b0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 unknown command, then back to stage one
        sync_in();
        expect_reply("R3 bad cmd echo", 8'h41, 8'h41);
        expect_reply("R3 bad reply B", 8'h11, 8'h42);
        expect_reply("R3 bad reply X", 8'h22, 8'h58);
        expect_reply("R3 back in stage one", 8'h42, 8'h42);
        // directed corners
        session(8'h58, 32'h8001_0000, 5, 0, 1'b1);
        session(8'h58, 32'h0000_1234, 0, 0, 1'b1);   // R6 zero length
        session(8'h55, 32'h1F00_0000, 0, 0, 1'b1);   // R6 zero length flash
        session(8'h58, 32'hA0B0_C0D0, 40, 1, 1'b1);  // R7 upper nibble ignored
        session(8'h58, 32'h0000_0100, 7, 2, 1'b1);   // R7 bad checksum
        session(8'h55, 32'h1F02_0000, 9, 0, 1'b0);   // R10 burn fail
        session(8'h55, 32'h1F04_0000, 12, 2, 1'b1);  // R8 BC on flash
        // R11 random sessions
        for (int k = 0; k < 10; k++) begin
            session(($urandom % 2) ? 8'h58 : 8'h55, $urandom, int'($urandom % 30),
                    int'($urandom % 3), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule